// File: doc/BRIEF.md
# CAN Self-Test Loopback Controller

This block sits between a CAN protocol engine and the transceiver pins. It adds two self-test behaviours without touching bit timing, stuffing, CRC or arbitration. Those stay in the engine, which reports the acknowledge slot and frame completion through strobes.

In isolated loopback, which is the default, the transmit pin is parked recessive. The engine hears its own transmit bit, and a dominant bit is forced into its receive path during the acknowledge slot. A frame can therefore finish with no other node on the bus, and both completion flags are raised.

In on-bus self-reception, the frame goes out on the real bus and the engine listens to the receive pin. The acknowledge has to come from another node. The node keeps its own frame as received only when the acceptance filter, which is supplied as an input, reports a match at end of frame.

The mode select is taken only while the bus is idle, so no frame changes path partway through. Both completion flags are sticky and are cleared by write-one-to-clear strobes.

Top module: `loopback_selftest`

## Requirements
- R1: After a synchronous reset, both flags are 0, the block is in loopback mode, and txPin is 1 (recessive).
- R2: With modeSel=0 (loopback), engRxBit equals engTxBit whenever ackSlot is low.
- R3: In loopback, engRxBit is 0 (dominant) whenever ackSlot is high, whatever engTxBit is.
- R4: In loopback, rxPin has no effect on engRxBit.
- R5: In loopback, txPin is 1 for every value of engTxBit.
- R6: In loopback, a txDone pulse sets both txIrq and rxIrq on the following clock edge, whatever filterMatch is.
- R7: With modeSel=1 (on-bus), txPin equals engTxBit and engRxBit equals rxPin, and ackSlot has no effect.
- R8: In on-bus mode, txDone sets txIrq only. rxDone sets rxIrq only if filterMatch is high in the same cycle.
- R9: The flags hold until cleared. clrFlags bit 0 clears txIrq and bit 1 clears rxIrq. A set in the same cycle as a clear wins.
- R10: modeSel is sampled only on clock edges where busIdle is high, and the new mode acts from the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busIdle | input | 1 | High while no frame is in progress |
| modeSel | input | 1 | 0 = isolated loopback, 1 = on-bus self-reception |
| engTxBit | input | 1 | Serial transmit bit from the protocol engine |
| rxPin | input | 1 | Receive pin from the transceiver |
| ackSlot | input | 1 | High during the acknowledge bit slot |
| txDone | input | 1 | One-cycle pulse: own frame transmitted successfully |
| rxDone | input | 1 | One-cycle pulse: frame reception complete |
| filterMatch | input | 1 | Acceptance filter identifier match, valid with rxDone |
| clrFlags | input | 2 | Write-one-to-clear strobes: bit 0 txIrq, bit 1 rxIrq |
| txPin | output | 1 | Transmit pin to the transceiver |
| engRxBit | output | 1 | Receive bit fed to the protocol engine |
| txIrq | output | 1 | Sticky transmit-complete flag |
| rxIrq | output | 1 | Sticky receive-complete flag |

## Verification
A mode register that is wrong shows up within one bit time. txPin drives the bus when it should be parked, or stays recessive when it should transmit. The missing or stray forced dominant bit appears on engRxBit as soon as ackSlot rises. A flag-update fault shows one edge after a completion pulse or clear strobe, as a flag that is missing, extra, or lost in a set-versus-clear collision. The bench sweeps every pin combination in both modes and every pulse and filter combination, and compares each result with values it computes from the rules above.

// File: rtl/lbst_pkg.sv
package lbst_pkg;
  typedef enum logic {
    MODE_LOOP  = 1'b0,
    MODE_ONBUS = 1'b1
  } lbMode_e;

  localparam logic LVL_DOMINANT  = 1'b0;
  localparam logic LVL_RECESSIVE = 1'b1;

  localparam int FLAG_W  = 2;
  localparam int FLAG_TX = 0;
  localparam int FLAG_RX = 1;

  typedef struct packed {
    logic [FLAG_W-1:0] set;
    logic [FLAG_W-1:0] clr;
  } flagStrobe_t;
endpackage

// File: rtl/lbst_ctrl.sv
module lbst_ctrl
  import lbst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busIdle,
  input  logic              modeSel,
  input  logic              txDone,
  input  logic              rxDone,
  input  logic              filterMatch,
  input  logic [FLAG_W-1:0] clrFlags,
  output lbMode_e           curMode,
  output flagStrobe_t       strobes
);
  always_ff @(posedge clk) begin
    if (rst) begin
      curMode <= MODE_LOOP;
    end else if (busIdle) begin
      curMode <= modeSel ? MODE_ONBUS : MODE_LOOP;
    end
  end

  logic ownAsRx;
  logic filteredRx;

  always_comb begin
    ownAsRx    = (curMode == MODE_LOOP) && txDone;
    filteredRx = rxDone && filterMatch;
    strobes.set          = '0;
    strobes.set[FLAG_TX] = txDone;
    strobes.set[FLAG_RX] = ownAsRx || filteredRx;
    strobes.clr          = clrFlags;
  end
endmodule

// File: rtl/lbst_path.sv
module lbst_path
  import lbst_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lbMode_e     curMode,
  input  flagStrobe_t strobes,
  input  logic        engTxBit,
  input  logic        rxPin,
  input  logic        ackSlot,
  output logic        txPin,
  output logic        engRxBit,
  output logic        txIrq,
  output logic        rxIrq
);
  logic [FLAG_W-1:0] flagQ;

  for (genvar g = 0; g < FLAG_W; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (rst) flagQ[g] <= 1'b0;
      else     flagQ[g] <= strobes.set[g] | (flagQ[g] & ~strobes.clr[g]);
    end
  end

  always_comb begin
    if (curMode == MODE_LOOP) begin
      txPin    = LVL_RECESSIVE;
      engRxBit = ackSlot ? LVL_DOMINANT : engTxBit;
    end else begin
      txPin    = engTxBit;
      engRxBit = rxPin;
    end
  end

  assign txIrq = flagQ[FLAG_TX];
  assign rxIrq = flagQ[FLAG_RX];
endmodule

// File: rtl/loopback_selftest.sv
module loopback_selftest
  import lbst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       busIdle,
  input  logic       modeSel,
  input  logic       engTxBit,
  input  logic       rxPin,
  input  logic       ackSlot,
  input  logic       txDone,
  input  logic       rxDone,
  input  logic       filterMatch,
  input  logic [1:0] clrFlags,
  output logic       txPin,
  output logic       engRxBit,
  output logic       txIrq,
  output logic       rxIrq
);
  lbMode_e     curMode;
  flagStrobe_t strobes;

  lbst_ctrl uCtrl (
    .clk(clk), .rst(rst), .busIdle(busIdle), .modeSel(modeSel),
    .txDone(txDone), .rxDone(rxDone), .filterMatch(filterMatch),
    .clrFlags(clrFlags), .curMode(curMode), .strobes(strobes)
  );

  lbst_path uPath (
    .clk(clk), .rst(rst), .curMode(curMode), .strobes(strobes),
    .engTxBit(engTxBit), .rxPin(rxPin), .ackSlot(ackSlot),
    .txPin(txPin), .engRxBit(engRxBit), .txIrq(txIrq), .rxIrq(rxIrq)
  );
endmodule

// File: rtl/lbst_checker.sv
module lbst_checker
  import lbst_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       busIdle,
  input lbMode_e    curMode,
  input logic       engTxBit,
  input logic       rxPin,
  input logic       ackSlot,
  input logic       txDone,
  input logic [1:0] clrFlags,
  input logic       txPin,
  input logic       engRxBit,
  input logic       txIrq,
  input logic       rxIrq
);
  assert_loop_recessive_R5: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_LOOP) |-> txPin);

  assert_dummy_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_LOOP && ackSlot) |-> !engRxBit);

  assert_onbus_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_ONBUS) |-> (engRxBit == rxPin && txPin == engTxBit));

  assert_loop_both_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (curMode == MODE_LOOP && txDone) |=> (txIrq && rxIrq));

  assert_clear_tx_R9: assert property (@(posedge clk) disable iff (rst)
    (clrFlags[0] && !txDone) |=> !txIrq);

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !busIdle |=> $stable(curMode));
endmodule

bind loopback_selftest lbst_checker uChk (
  .clk(clk), .rst(rst), .busIdle(busIdle), .curMode(curMode),
  .engTxBit(engTxBit), .rxPin(rxPin), .ackSlot(ackSlot), .txDone(txDone),
  .clrFlags(clrFlags), .txPin(txPin), .engRxBit(engRxBit),
  .txIrq(txIrq), .rxIrq(rxIrq)
);

// File: tb/tb_loopback_selftest.sv
module tb_loopback_selftest;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, busIdle, modeSel, engTxBit, rxPin, ackSlot;
  logic txDone, rxDone, filterMatch;
  logic [1:0] clrFlags;
  logic txPin, engRxBit, txIrq, rxIrq;

  int nCmp = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loopback_selftest dut (
    .clk(clk), .rst(rst), .busIdle(busIdle), .modeSel(modeSel),
    .engTxBit(engTxBit), .rxPin(rxPin), .ackSlot(ackSlot),
    .txDone(txDone), .rxDone(rxDone), .filterMatch(filterMatch),
    .clrFlags(clrFlags), .txPin(txPin), .engRxBit(engRxBit),
    .txIrq(txIrq), .rxIrq(rxIrq)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic quiet();
    txDone = 0; rxDone = 0; filterMatch = 0; clrFlags = 2'b00;
  endtask

  task automatic selectMode(input logic m);
    busIdle = 1; modeSel = m;
    step();
  endtask

  task automatic clearAll();
    clrFlags = 2'b11;
    step();
    clrFlags = 2'b00;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nBad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    rst = 1; busIdle = 1; modeSel = 0; engTxBit = 1; rxPin = 1; ackSlot = 0;
    quiet();
    step(); step();
    rst = 0;
    #1;
    // R1 reset state
    engTxBit = 0;
    #1;
    chk("R1 txPin recessive", txPin, 1'b1);
    chk("R1 txIrq", txIrq, 1'b0);
    chk("R1 rxIrq", rxIrq, 1'b0);

    // pin sweep, both modes
    for (int m = 0; m < 2; m++) begin
      selectMode(m[0]);
      for (int v = 0; v < 8; v++) begin
        engTxBit = v[0]; rxPin = v[1]; ackSlot = v[2];
        #1;
        if (m == 0) begin
          chk("R5 loop txPin", txPin, 1'b1);
          if (v[2]) chk("R3 dummy ack", engRxBit, 1'b0);
          else      chk("R2 R4 loop rx echo", engRxBit, v[0]);
        end else begin
          chk("R7 onbus txPin", txPin, v[0]);
          chk("R7 onbus rx", engRxBit, v[1]);
        end
      end
      ackSlot = 0;

      // interrupt sweep
      for (int p = 0; p < 8; p++) begin
        txDone = p[0]; rxDone = p[1]; filterMatch = p[2];
        step();
        quiet();
        if (m == 0) begin
          chk("R6 loop txIrq", txIrq, p[0]);
          chk("R6 loop rxIrq", rxIrq, p[0] | (p[1] & p[2]));
        end else begin
          chk("R8 onbus txIrq", txIrq, p[0]);
          chk("R8 onbus rxIrq", rxIrq, p[1] & p[2]);
        end
        step();
        chk("R9 sticky txIrq", txIrq, p[0]);
        clearAll();
        chk("R9 cleared tx", txIrq, 1'b0);
        chk("R9 cleared rx", rxIrq, 1'b0);
      end
    end

    // R9 selective clear and set-wins
    selectMode(1'b0);
    txDone = 1; step(); quiet();
    clrFlags = 2'b01; step(); clrFlags = 2'b00;
    chk("R9 clr bit0 tx", txIrq, 1'b0);
    chk("R9 clr bit0 keeps rx", rxIrq, 1'b1);
    clrFlags = 2'b10; txDone = 1; step(); quiet();
    chk("R9 set wins tx", txIrq, 1'b1);
    chk("R9 set wins rx", rxIrq, 1'b1);
    clearAll();

    // R10 mode change only while idle
    busIdle = 0; modeSel = 1; engTxBit = 0;
    step(); step();
    chk("R10 busy hold loop", txPin, 1'b1);
    busIdle = 1;
    #1;
    chk("R10 not before edge", txPin, 1'b1);
    step();
    chk("R10 switched onbus", txPin, 1'b0);
    busIdle = 0; modeSel = 0;
    step();
    chk("R10 busy hold onbus", txPin, 1'b0);
    busIdle = 1; step();
    chk("R10 back to loop", txPin, 1'b1);

    // R1 reset from on-bus with flags set
    selectMode(1'b1);
    txDone = 1; step(); quiet();
    rst = 1; step(); rst = 0; busIdle = 0; engTxBit = 0;
    #1;
    chk("R1 reset txIrq", txIrq, 1'b0);
    chk("R1 reset mode loop", txPin, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule